// File: doc/BRIEF.md
# Periodic Compare Trigger Timer

The block holds a free-running up-counter and two compare channels. One channel, the set compare, raises a level flag when the counter reaches its value. The other, the clear compare, drops the flag again when automatic clear is on. After each match, a channel adds one shared step value to its own compare register. With the two compare values offset inside one step, the flag becomes a periodic rectangular wave. Another peripheral, such as a converter start input, can use this wave as a trigger, and no processor has to service each edge.

The raw flag leaves the block directly as the trigger output, and no enable stands in its path. A second output ANDs the flag with an interrupt enable and acts as the interrupt request. Software writes the control bits, the two compare values and the step through a simple write port. It can also clear the flag by writing a one to the flag address.

The flag is held by a two-state machine. `FLAG_LOW` is the idle state and `FLAG_HIGH` is the asserted state. The `ARM` transition goes from `FLAG_LOW` to `FLAG_HIGH` on a set match. The `DISARM` transition goes from `FLAG_HIGH` to `FLAG_LOW` on an enabled clear match or a software clear, unless a set match occurs in the same cycle. In every other case the machine stays in its state (`HOLD`).

Top module: `cmp_pulse_timer`

## Requirements
- R1: After reset, trig_o and irq_o are 0, the counter is 0, the run, auto-clear and interrupt-enable bits are 0, and the set compare, clear compare and step hold their parameter values (defaults 10, 15 and 10).
- R2: The counter advances by one per clock only while the run bit (bit 0 at address 0) is 1. Compare matches count only while that bit is 1.
- R3: When the counter equals the set compare value while running, the flag is 1 from the next cycle.
- R4: With auto-clear (bit 1 at address 0) set, a counter value equal to the clear compare drives the flag to 0 from the next cycle. With the default values the flag is high for 5 cycles out of every 10.
- R5: On each match a compare register adds the step to itself, so successive rising edges are exactly one step apart.
- R6: With auto-clear off, the flag, once set, stays 1 with no further edges until software clears it.
- R7: Writing a 1 to bit 0 at address 4 clears the flag. A set match in the same cycle wins, and the flag stays 1.
- R8: trig_o equals the raw flag whatever the interrupt enable is. irq_o equals the flag ANDed with the interrupt enable (bit 2 at address 0).
- R9: Writes to address 0 (control), 1 (set compare), 2 (clear compare) and 3 (step) take effect from the next cycle. A new step governs every advance that follows.
- R10: A write to a compare register in the same cycle as that register's match loads the written value, and the advance by the step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | W | Write data |
| trig_o | output | 1 | Raw flag, used as the peripheral trigger |
| irq_o | output | 1 | Flag gated by the interrupt enable |

## Verification
The bench aims at the cycle in which a set match and a flag-clear write land together. A design that let the clear win would lose a trigger edge there. It also writes a new set value in the very cycle of a match. A design that advanced the register anyway would place the next rising edge one step away, when it should be twenty cycles away. Runs without auto-clear test that the flag never falls on its own. A design that let the clear channel act regardless of the enable would keep toggling. Runs with the interrupt enable off test that the trigger still moves. A design that took the trigger after the gate would stay silent in those runs.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

    localparam int unsigned ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_SET  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CLR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_STEP = 3'd3;
    localparam logic [ADDR_W-1:0] A_FLAG = 3'd4;

    localparam int unsigned CTRL_RUN  = 0;
    localparam int unsigned CTRL_AUTO = 1;
    localparam int unsigned CTRL_IRQ  = 2;

    localparam int unsigned NUM_CMP = 2;
    localparam int unsigned CMP_SET = 0;
    localparam int unsigned CMP_CLR = 1;
endpackage

// File: rtl/cpt_counter.sv
module cpt_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt)); // R2
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> (cnt == W'($past(cnt) + 1'b1))); // R2
endmodule

// File: rtl/cpt_cmp_chan.sv
module cpt_cmp_chan #(
    parameter int unsigned   W    = 16,
    parameter logic [W-1:0]  INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] step,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         hit
);
    logic [W-1:0] cmp_q;

    assign hit = run && (cnt == cmp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= INIT;
        end else if (load) begin
            cmp_q <= load_val;
        end else if (hit) begin
            cmp_q <= cmp_q + step;
        end
    end

    AST_CMP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !load) |=> (cmp_q == W'($past(cmp_q) + $past(step)))); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cmp_q == $past(load_val))); // R10
endmodule

// File: rtl/cpt_flag_fsm.sv
module cpt_flag_fsm
    import cpt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_hit,
    input  logic clr_hit,
    input  logic sw_clr,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_LOW: begin
                if (set_hit) state_d = FLAG_HIGH;             // ARM
            end
            FLAG_HIGH: begin
                if (set_hit)                 state_d = FLAG_HIGH; // set wins
                else if (clr_hit || sw_clr)  state_d = FLAG_LOW;  // DISARM
            end
            default: state_d = FLAG_LOW;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        flag = (state_q == FLAG_HIGH);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_hit |=> flag); // R7
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_hit && !sw_clr) |=> flag); // R6
    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(set_hit)); // R3
endmodule

// File: rtl/cmp_pulse_timer.sv
module cmp_pulse_timer
    import cpt_pkg::*;
#(
    parameter int unsigned W         = 16,
    parameter int unsigned INIT_SET  = 10,
    parameter int unsigned INIT_CLR  = 15,
    parameter int unsigned INIT_STEP = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic              trig_o,
    output logic              irq_o
);
    localparam logic [W-1:0] SET_V  = W'(INIT_SET);
    localparam logic [W-1:0] CLR_V  = W'(INIT_CLR);
    localparam logic [W-1:0] STEP_V = W'(INIT_STEP);

    logic               run_q, auto_q, irq_en_q;
    logic [W-1:0]       step_q;
    logic [W-1:0]       cnt;
    logic [NUM_CMP-1:0] hit;
    logic [NUM_CMP-1:0] load;
    logic               sw_clr;
    logic               flag;

    // control and step registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            auto_q   <= 1'b0;
            irq_en_q <= 1'b0;
            step_q   <= STEP_V;
        end else if (wr_en) begin
            if (wr_addr == A_CTRL) begin
                run_q    <= wr_data[CTRL_RUN];
                auto_q   <= wr_data[CTRL_AUTO];
                irq_en_q <= wr_data[CTRL_IRQ];
            end
            if (wr_addr == A_STEP) step_q <= wr_data;
        end
    end

    assign load[CMP_SET] = wr_en && (wr_addr == A_SET);
    assign load[CMP_CLR] = wr_en && (wr_addr == A_CLR);
    assign sw_clr        = wr_en && (wr_addr == A_FLAG) && wr_data[0];

    cpt_counter #(.W(W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run_q),
        .cnt   (cnt)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_chan
        localparam logic [W-1:0] INIT_G = (g == CMP_SET) ? SET_V : CLR_V;
        cpt_cmp_chan #(.W(W), .INIT(INIT_G)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q),
            .cnt      (cnt),
            .step     (step_q),
            .load     (load[g]),
            .load_val (wr_data),
            .hit      (hit[g])
        );
    end

    cpt_flag_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_hit (hit[CMP_SET]),
        .clr_hit (hit[CMP_CLR] && auto_q),
        .sw_clr  (sw_clr),
        .flag    (flag)
    );

    assign trig_o = flag;
    assign irq_o  = flag && irq_en_q;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> trig_o); // R8
    AST_NO_MATCH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (hit == '0)); // R2
endmodule

// File: tb/sim_cmp_pulse_timer.sv
module sim_cmp_pulse_timer;
    import cpt_pkg::*;

    localparam int  W      = 16;
    localparam time PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         trig_o, irq_o;

    always #(PERIOD/2) clk = ~clk;

    cmp_pulse_timer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_o(trig_o), .irq_o(irq_o)
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int irq_hi = 0;
    int rises[$];
    int falls[$];
    bit prev_trig = 1'b0;

    // behavioural reference, updated on each rising edge
    logic [W-1:0] m_cnt, m_set, m_clr, m_step;
    bit m_run, m_auto, m_irq, m_flag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_set = 10; m_clr = 15; m_step = 10;
            m_run = 0; m_auto = 0; m_irq = 0; m_flag = 0;
        end else begin
            bit sh, ch, sw;
            logic [W-1:0] ns, nc;
            sh = m_run && (m_cnt == m_set);
            ch = m_run && (m_cnt == m_clr);
            sw = wr_en && (wr_addr == 3'd4) && wr_data[0];
            if (sh) m_flag = 1;
            else if ((m_auto && ch) || sw) m_flag = 0;
            ns = (wr_en && wr_addr == 3'd1) ? wr_data : (sh ? W'(m_set + m_step) : m_set);
            nc = (wr_en && wr_addr == 3'd2) ? wr_data : (ch ? W'(m_clr + m_step) : m_clr);
            if (m_run) m_cnt = m_cnt + 1'b1;
            if (wr_en && wr_addr == 3'd0) begin
                m_run = wr_data[0]; m_auto = wr_data[1]; m_irq = wr_data[2];
            end
            if (wr_en && wr_addr == 3'd3) m_step = wr_data;
            m_set = ns;
            m_clr = nc;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison and edge log, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(trig_o === m_flag, "R3", "trig vs model", int'(trig_o), int'(m_flag));
            chk(irq_o === (m_flag && m_irq), "R8", "irq vs model", int'(irq_o), int'(m_flag && m_irq));
            if (trig_o && !prev_trig) rises.push_back(cyc);
            if (!trig_o && prev_trig) falls.push_back(cyc);
            if (irq_o) irq_hi++;
        end
        prev_trig = trig_o;
    end

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_cond_set_match();
        int g = 0;
        while (!(m_run && m_cnt == m_set) && g < 200) begin
            @(negedge clk);
            g++;
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] c;
        repeat (3) @(negedge clk);
        chk(trig_o == 1'b0 && irq_o == 1'b0, "R1", "outputs in reset", int'(trig_o | irq_o), 0);
        rst_n = 1'b1;

        // R2: stopped counter never reaches the set value
        repeat (30) @(negedge clk);
        chk(rises.size() == 0, "R2", "rises while stopped", rises.size(), 0);

        // R4/R5: auto-clear wave with defaults, irq off
        rises.delete(); falls.delete(); irq_hi = 0;
        wr(A_CTRL, 16'h3);
        repeat (65) @(negedge clk);
        chk(rises.size() >= 5, "R5", "rise count", rises.size(), 5);
        for (int i = 1; i < rises.size(); i++)
            chk(rises[i] - rises[i-1] == 10, "R5", "rise spacing", rises[i] - rises[i-1], 10);
        for (int i = 0; i < rises.size() && i < falls.size(); i++)
            chk(falls[i] - rises[i] == 5, "R4", "high time", falls[i] - rises[i], 5);
        chk(irq_hi == 0, "R8", "irq while disabled", irq_hi, 0);

        // R8: enable irq
        wr(A_CTRL, 16'h7);
        begin
            int g = 0;
            while (!trig_o && g < 50) begin @(negedge clk); g++; end
        end
        chk(irq_o == 1'b1, "R8", "irq follows flag", int'(irq_o), 1);

        // R6: no auto-clear, flag latches
        wr(A_CTRL, 16'h5);
        begin
            int g = 0;
            while (!m_flag && g < 50) begin @(negedge clk); g++; end
        end
        rises.delete(); falls.delete();
        repeat (40) @(negedge clk);
        chk(falls.size() == 0 && trig_o == 1'b1, "R6", "flag holds", falls.size(), 0);

        // R7: clear collides with set match -> set wins
        wait_cond_set_match();
        wr(A_FLAG, 16'h1);
        chk(trig_o == 1'b1, "R7", "set beats clear", int'(trig_o), 1);
        wr(A_FLAG, 16'h1);
        chk(trig_o == 1'b0, "R7", "software clear", int'(trig_o), 0);

        // R9: reprogram step and compares while stopped
        wr(A_CTRL, 16'h0);
        c = m_cnt;
        wr(A_STEP, 16'd6);
        wr(A_SET, W'(c + 3));
        wr(A_CLR, W'(c + 5));
        rises.delete(); falls.delete();
        wr(A_CTRL, 16'h7);
        repeat (40) @(negedge clk);
        chk(rises.size() >= 4, "R9", "rises after reprogram", rises.size(), 4);
        for (int i = 1; i < rises.size(); i++)
            chk(rises[i] - rises[i-1] == 6, "R9", "new step spacing", rises[i] - rises[i-1], 6);
        for (int i = 0; i < rises.size() && i < falls.size(); i++)
            chk(falls[i] - rises[i] == 2, "R4", "new high time", falls[i] - rises[i], 2);

        // R10: load in the match cycle overrides advance
        wait_cond_set_match();
        rises.delete();
        wr(A_SET, W'(m_cnt + 20));
        repeat (30) @(negedge clk);
        chk(rises.size() >= 2, "R10", "rises after load", rises.size(), 2);
        if (rises.size() >= 2)
            chk(rises[1] - rises[0] == 20, "R10", "gap after load", rises[1] - rises[0], 20);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule